// File: doc/BRIEF.md
# Byte ALU with Flag-Protected Status Register

This block is the arithmetic unit and status-flag update path of a small byte-wide RISC core. On each executed instruction it takes the working register, a second operand (a file register value or a literal), a 4-bit operation code, a destination-select bit and the bit index for bit operations. It computes the result and decides whether that result goes to the working register or to the addressed file register. Both decisions are combinational.

The block holds the STATUS register. This register contains the carry (C), digit carry (DC) and zero (Z) flags, a program page select and a data bank select. When an instruction that produces flags also writes its result to STATUS, the produced flags take priority over the written value for those bits. Plain moves and bit set/clear operations leave the flags alone, so they can write every bit of STATUS. In subtraction the carry and digit carry are the inverse of a borrow.

Top module: `alu_status_unit`

## Requirements
- R1: After reset, status_out is 0x00, so rom_page and ram_bank are both 0.
- R2: Opcode encoding: 0 MOVF, 1 MOVWF, 2 ADD, 3 SUB, 4 AND, 5 OR, 6 XOR, 7 COMF, 8 RLC, 9 RRC, 10 BSET, 11 BCLR, 15 NOP. MOVWF (result = W), BSET and BCLR always write the file (f_we=1). NOP writes nothing. Every other operation writes W when dest_f=0 and the file when dest_f=1. w_we and f_we are never both 1.
- R3: ADD gives f+W. C (STATUS bit 0) is the carry out of bit 7. DC (bit 1) is the carry out of bit 3. Z (bit 2) is 1 when the result is zero.
- R4: SUB gives f-W, computed as f+~W+1. C is 1 when no borrow occurs. DC is 1 when the low nibble does not borrow. Z marks a zero result.
- R5: MOVF (result = f), AND, OR, XOR and COMF (result = ~f) update Z only. C and DC keep their values.
- R6: RLC gives {f[6:0],C} with the new C = f[7]. RRC gives {C,f[7:1]} with the new C = f[0]. Rotates update only C.
- R7: When a flag-producing operation writes STATUS, bits 0..2 take the produced flags where that operation affects them. All other bits, and any flag the operation does not affect, take the result.
- R8: MOVWF, BSET (result = f with bit b set) and BCLR (result = f with bit b cleared), when they target STATUS, load all eight bits from the result.
- R9: rom_page follows STATUS bit 6 and ram_bank follows STATUS bit 4.
- R10: With op_valid=0, both write enables are 0 and STATUS holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An instruction executes this cycle |
| op_code | input | 4 | Operation code |
| dest_f | input | 1 | Destination select: 0 = W, 1 = file |
| f_is_status | input | 1 | The addressed file register is STATUS |
| bit_sel | input | 3 | Bit index for BSET/BCLR |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | File register value or literal |
| res_out | output | 8 | Operation result |
| w_we | output | 1 | Write result to W |
| f_we | output | 1 | Write result to the file register |
| status_out | output | 8 | STATUS register |
| rom_page | output | 1 | Program page select |
| ram_bank | output | 1 | Data bank select |

## Verification
The hardest case to reach from the ports is a flag-producing operation aimed at STATUS whose result has a different value in the flag bits. That case shows whether the produced flags win over the written value or the other way round. The stimulus first loads STATUS with known contents through a move. It then runs an ADD and an AND into STATUS, with operands chosen so that the written flag bits and the produced flags disagree. Finally it runs a rotate into STATUS, where only C must be overridden.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;
   typedef enum logic [3:0] {
      OP_MOVF  = 4'd0,
      OP_MOVWF = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_AND   = 4'd4,
      OP_OR    = 4'd5,
      OP_XOR   = 4'd6,
      OP_COMF  = 4'd7,
      OP_RLC   = 4'd8,
      OP_RRC   = 4'd9,
      OP_BSET  = 4'd10,
      OP_BCLR  = 4'd11,
      OP_NOP   = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic c;
      logic dc;
      logic z;
   } flag_t;
endpackage

// File: rtl/alu_status_core.sv
module alu_status_core
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int HALF_W = DATA_W / 2,
   localparam int BIT_W = $clog2(DATA_W)
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] w_val,
   input  logic [DATA_W-1:0] f_val,
   input  logic              c_in,
   input  logic [BIT_W-1:0]  bit_idx,
   output logic [DATA_W-1:0] res,
   output flag_t             flags,
   output flag_t             affects
);
   logic              is_sub;
   logic [DATA_W-1:0] addend;
   logic [DATA_W:0]   full_sum;
   logic [HALF_W:0]   half_sum;

   assign is_sub   = (op == OP_SUB);
   assign addend   = is_sub ? ~w_val : w_val;
   assign full_sum = {1'b0, f_val} + {1'b0, addend} + {{DATA_W{1'b0}}, is_sub};
   assign half_sum = {1'b0, f_val[HALF_W-1:0]} + {1'b0, addend[HALF_W-1:0]}
                   + {{HALF_W{1'b0}}, is_sub};

   always_comb begin
      res     = f_val;
      flags   = '0;
      affects = '0;
      unique case (op)
         OP_MOVF:  begin res = f_val; affects.z = 1'b1; end
         OP_MOVWF: res = w_val;
         OP_ADD, OP_SUB: begin
            res      = full_sum[DATA_W-1:0];
            flags.c  = full_sum[DATA_W];
            flags.dc = half_sum[HALF_W];
            affects  = '1;
         end
         OP_AND:  begin res = f_val & w_val; affects.z = 1'b1; end
         OP_OR:   begin res = f_val | w_val; affects.z = 1'b1; end
         OP_XOR:  begin res = f_val ^ w_val; affects.z = 1'b1; end
         OP_COMF: begin res = ~f_val;        affects.z = 1'b1; end
         OP_RLC: begin
            res       = {f_val[DATA_W-2:0], c_in};
            flags.c   = f_val[DATA_W-1];
            affects.c = 1'b1;
         end
         OP_RRC: begin
            res       = {c_in, f_val[DATA_W-1:1]};
            flags.c   = f_val[0];
            affects.c = 1'b1;
         end
         OP_BSET: res = f_val | (DATA_W'(1) << bit_idx);
         OP_BCLR: res = f_val & ~(DATA_W'(1) << bit_idx);
         default: res = f_val;
      endcase
      flags.z = (res == '0);
   end
endmodule

// File: rtl/alu_status_route.sv
module alu_status_route
   import alu_status_pkg::*;
(
   input  logic    valid,
   input  alu_op_e op,
   input  logic    dest_sel,
   output logic    to_w,
   output logic    to_f
);
   always_comb begin
      to_w = 1'b0;
      to_f = 1'b0;
      if (valid) begin
         case (op)
            OP_MOVWF, OP_BSET, OP_BCLR: to_f = 1'b1;
            OP_MOVF, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_COMF,
            OP_RLC, OP_RRC: begin
               to_w = ~dest_sel;
               to_f = dest_sel;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_status_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int C_POS  = 0,
   parameter int DC_POS = 1,
   parameter int Z_POS  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic              wr_direct,
   input  logic [DATA_W-1:0] wr_val,
   input  flag_t             flags,
   input  flag_t             affects,
   output logic [DATA_W-1:0] stat
);
   logic [DATA_W-1:0] stat_nxt;

   always_comb begin
      stat_nxt = wr_direct ? wr_val : stat;
      if (affects.c)  stat_nxt[C_POS]  = flags.c;
      if (affects.dc) stat_nxt[DC_POS] = flags.dc;
      if (affects.z)  stat_nxt[Z_POS]  = flags.z;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat <= '0;
      else if (upd_en) stat <= stat_nxt;
   end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
   import alu_status_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int C_POS    = 0,
   parameter int DC_POS   = 1,
   parameter int Z_POS    = 2,
   parameter int BANK_POS = 4,
   parameter int PAGE_POS = 6,
   localparam int BIT_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              dest_f,
   input  logic              f_is_status,
   input  logic [BIT_W-1:0]  bit_sel,
   input  logic [DATA_W-1:0] w_in,
   input  logic [DATA_W-1:0] f_in,
   output logic [DATA_W-1:0] res_out,
   output logic              w_we,
   output logic              f_we,
   output logic [DATA_W-1:0] status_out,
   output logic              rom_page,
   output logic              ram_bank
);
   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("DATA_W must be even and at least 4");
      end
      if (C_POS >= DATA_W || DC_POS >= DATA_W || Z_POS >= DATA_W ||
          BANK_POS >= DATA_W || PAGE_POS >= DATA_W) begin : g_bad_pos
         $error("status bit position outside the data width");
      end
      if (C_POS == DC_POS || C_POS == Z_POS || DC_POS == Z_POS) begin : g_flag_clash
         $error("flag positions must be distinct");
      end
   endgenerate

   alu_op_e op;
   flag_t   flags, affects, affects_gated;
   logic    wr_status;

   assign op = alu_op_e'(op_code);

   alu_status_core #(.DATA_W(DATA_W)) u_core (
      .op(op), .w_val(w_in), .f_val(f_in), .c_in(status_out[C_POS]),
      .bit_idx(bit_sel), .res(res_out), .flags(flags), .affects(affects)
   );

   alu_status_route u_route (
      .valid(op_valid), .op(op), .dest_sel(dest_f), .to_w(w_we), .to_f(f_we)
   );

   assign wr_status     = f_we & f_is_status;
   assign affects_gated = (op_valid && op != OP_NOP) ? affects : '0;

   alu_status_reg #(
      .DATA_W(DATA_W), .C_POS(C_POS), .DC_POS(DC_POS), .Z_POS(Z_POS)
   ) u_stat (
      .clk(clk), .rst_n(rst_n), .upd_en(op_valid), .wr_direct(wr_status),
      .wr_val(res_out), .flags(flags), .affects(affects_gated), .stat(status_out)
   );

   assign rom_page = status_out[PAGE_POS];
   assign ram_bank = status_out[BANK_POS];
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk
   import alu_status_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid,
   input logic [3:0] op_code,
   input logic       f_is_status,
   input logic [7:0] res_out,
   input logic       w_we,
   input logic       f_we,
   input logic [7:0] status_out
);
   // R10: an idle cycle leaves STATUS untouched
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(status_out));

   // R10: no write enable without a valid instruction
   a_r10_no_we: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!w_we && !f_we));

   // R2: a result never goes to both destinations
   a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
      !(w_we && f_we));

   // R7: for ADD into STATUS, the bits above the flags come from the result
   a_r7_upper_from_res: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ADD && f_we && f_is_status)
      |=> status_out[7:3] == $past(res_out[7:3]));

   // R8: MOVWF into STATUS loads every bit
   a_r8_movwf_all: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_MOVWF && f_is_status)
      |=> status_out == $past(res_out));

   // R6: a rotate that does not target STATUS keeps DC and Z
   a_r6_rot_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == OP_RLC || op_code == OP_RRC) && !(f_we && f_is_status))
      |=> status_out[2:1] == $past(status_out[2:1]));
endmodule

bind alu_status_unit alu_status_chk u_chk (.*);

// File: tb/sim_alu_status_unit.sv
`timescale 1ns/1ps
module sim_alu_status_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [3:0] op_code = 4'd15;
   logic       dest_f = 1'b0;
   logic       f_is_status = 1'b0;
   logic [2:0] bit_sel = '0;
   logic [7:0] w_in = '0;
   logic [7:0] f_in = '0;
   logic [7:0] res_out, status_out;
   logic       w_we, f_we, rom_page, ram_bank;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   alu_status_unit u0 (.*);

   // {op, d, is_status, bit, w, f, exp_res, exp_wwe, exp_fwe, exp_status_after}
   localparam int NV = 21;
   localparam logic [42:0] VEC [NV] = '{
      {4'd2, 1'b0,1'b0,3'd0, 8'h0F,8'h01, 8'h10, 1'b1,1'b0, 8'h02}, // R3 DC from nibble
      {4'd2, 1'b1,1'b0,3'd0, 8'hF0,8'h10, 8'h00, 1'b0,1'b1, 8'h05}, // R3 carry, zero
      {4'd3, 1'b0,1'b0,3'd0, 8'h01,8'h03, 8'h02, 1'b1,1'b0, 8'h03}, // R4 no borrow
      {4'd3, 1'b0,1'b0,3'd0, 8'h05,8'h03, 8'hFE, 1'b1,1'b0, 8'h00}, // R4 borrow
      {4'd3, 1'b0,1'b0,3'd0, 8'h22,8'h22, 8'h00, 1'b1,1'b0, 8'h07}, // R4 equal
      {4'd4, 1'b0,1'b0,3'd0, 8'h0F,8'hF0, 8'h00, 1'b1,1'b0, 8'h07}, // R5 AND
      {4'd5, 1'b0,1'b0,3'd0, 8'h0F,8'hF0, 8'hFF, 1'b1,1'b0, 8'h03}, // R5 OR
      {4'd6, 1'b1,1'b0,3'd0, 8'hAA,8'hAA, 8'h00, 1'b0,1'b1, 8'h07}, // R5 XOR
      {4'd8, 1'b0,1'b0,3'd0, 8'h00,8'h81, 8'h03, 1'b1,1'b0, 8'h07}, // R6 RLC C=1
      {4'd9, 1'b0,1'b0,3'd0, 8'h00,8'h02, 8'h81, 1'b1,1'b0, 8'h06}, // R6 RRC
      {4'd8, 1'b0,1'b0,3'd0, 8'h00,8'h40, 8'h80, 1'b1,1'b0, 8'h06}, // R6 RLC C=0
      {4'd0, 1'b0,1'b0,3'd0, 8'h00,8'h55, 8'h55, 1'b1,1'b0, 8'h02}, // R5 MOVF
      {4'd7, 1'b1,1'b0,3'd0, 8'h00,8'hFF, 8'h00, 1'b0,1'b1, 8'h06}, // R5 COMF
      {4'd1, 1'b0,1'b1,3'd0, 8'h50,8'h00, 8'h50, 1'b0,1'b1, 8'h50}, // R8 MOVWF
      {4'd10,1'b0,1'b1,3'd0, 8'h00,8'h50, 8'h51, 1'b0,1'b1, 8'h51}, // R8 BSET
      {4'd11,1'b0,1'b1,3'd6, 8'h00,8'h51, 8'h11, 1'b0,1'b1, 8'h11}, // R8 BCLR
      {4'd2, 1'b1,1'b1,3'd0, 8'h01,8'h06, 8'h07, 1'b0,1'b1, 8'h00}, // R7 ADD override
      {4'd1, 1'b0,1'b1,3'd0, 8'hFF,8'h00, 8'hFF, 1'b0,1'b1, 8'hFF}, // R8 MOVWF all ones
      {4'd4, 1'b1,1'b1,3'd0, 8'h57,8'hF7, 8'h57, 1'b0,1'b1, 8'h53}, // R7 AND only Z
      {4'd15,1'b1,1'b1,3'd0, 8'h12,8'h34, 8'h00, 1'b0,1'b0, 8'h53}, // R2 NOP
      {4'd9, 1'b1,1'b1,3'd0, 8'h00,8'h0E, 8'h87, 1'b0,1'b1, 8'h86}  // R7 RRC only C
   };

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] op, input logic d, input logic st,
                        input logic [2:0] b, input logic [7:0] w, input logic [7:0] f);
      op_code = op; dest_f = d; f_is_status = st; bit_sel = b; w_in = w; f_in = f;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 status after reset", status_out, 8'h00);
      check("R1/R9 page and bank after reset", {6'd0, rom_page, ram_bank}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      op_valid = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [42:0] v;
         v = VEC[i];
         drive(v[42:39], v[38], v[37], v[36:34], v[33:26], v[25:18]);
         #1;
         if (v[9] || v[8]) check($sformatf("R2-R8 vector %0d result", i), res_out, v[17:10]);
         check($sformatf("R2 vector %0d enables", i), {6'd0, w_we, f_we}, {6'd0, v[9], v[8]});
         @(negedge clk);
         check($sformatf("R3-R8 vector %0d status", i), status_out, v[7:0]);
      end

      // R10: idle cycle with an ADD aimed at STATUS changes nothing
      op_valid = 1'b0;
      drive(4'd2, 1'b1, 1'b1, 3'd0, 8'h11, 8'h22);
      #1;
      check("R10 enables low when idle", {6'd0, w_we, f_we}, 8'h00);
      @(negedge clk);
      check("R10 status holds when idle", status_out, 8'h86);

      // R9: page and bank follow bits 6 and 4
      op_valid = 1'b1;
      drive(4'd1, 1'b0, 1'b1, 3'd0, 8'h40, 8'h00);
      @(negedge clk);
      check("R9 page set bank clear", {6'd0, rom_page, ram_bank}, 8'h02);
      drive(4'd1, 1'b0, 1'b1, 3'd0, 8'h10, 8'h00);
      @(negedge clk);
      check("R9 page clear bank set", {6'd0, rom_page, ram_bank}, 8'h01);

      // R1: reset mid-run clears STATUS
      op_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 status cleared by reset", status_out, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule